// File: doc/BRIEF.md
# ADC Power-State Sequencer

This block decides, cycle by cycle, whether the analog core of a serial converter is powered, whether its bias generator stays alive, and whether the conversions it produces may be trusted. It watches the chip-select line and the conversion-start strobe through synchronisers. It also watches a software-start bit, a conversions-finished flag and the clock-mode select. It snoops 16-bit register writes to pick up a two-bit automatic power field and a two-bit static shutdown field.

A single state machine drives the outputs. It has seven states:

- **ON**: powered, chip-select idle.
- **FRAME**: powered, inside a chip-select frame.
- **FRAME_NEW**: powered, inside a frame during which the mode word was written.
- **DOWN**: automatic power-down.
- **WARM**: powering up outside a frame.
- **WARM_F**: powering up inside a frame.
- **STATIC**: static shutdown.

The transitions are:

- ON → FRAME on a chip-select fall.
- FRAME → FRAME_NEW on a mode write.
- FRAME → ON or DOWN on a chip-select rise.
- FRAME_NEW → ON on a chip-select rise.
- Any powered state → DOWN on a conversions-finished flag in internal-clock auto mode.
- DOWN → WARM_F on a chip-select fall in external-clock mode.
- DOWN → WARM on a conversion-start fall, or on a chip-select rise with the software bit set, in internal-clock mode.
- DOWN → WARM when the mode is rewritten to a non-automatic value.
- WARM → ON and WARM_F → FRAME after the warm-up count.
- WARM_F → DOWN on a chip-select rise in external-clock auto mode. On a rise in any other mode, WARM_F → WARM.
- Any state → STATIC while static shutdown is set.
- STATIC → WARM when static shutdown is cleared.

Top module: `adc_pwr_seq`

## Requirements
- R1: After a synchronous active-high reset, main_en, bias_en and conv_valid are all 1 and the automatic power field holds 00.
- R2: A write with bit 15 = 0 loads the automatic power field from bits 3:2. A write with bits 15:11 = 10000 loads the static field from bits 1:0. Any other word, such as bits 15:11 = 11000 or 10001, changes nothing.
- R3: With the automatic field at 00 or 11, chip-select frames, conversion-start edges and the conversions-finished flag never lower main_en.
- R4: In external-clock mode with field 01 or 10, the chip-select rise that ends the frame in which the mode word was written keeps the block powered.
- R5: In R4's mode, the chip-select rise that ends the following frame lowers main_en. bias_en is then 0 for field 01 and 1 for field 10, and bias_en is 1 whenever main_en is 1.
- R6: After every power-up, conv_valid stays 0 for exactly 2 clock cycles while main_en is 1, and then rises.
- R7: In internal-clock mode with field 01 or 10, a conversions-finished pulse while conversions are valid lowers main_en on the next clock edge.
- R8: In internal-clock auto power-down, a conversion-start fall wakes the block. A chip-select rise wakes it only when the software bit is 1. Chip-select falls do not wake it.
- R9: A static field of 01 turns off main_en and bias_en. A static field of 10 turns off main_en only. Static fields 00 and 11 have no effect.
- R10: While static shutdown is set, no chip-select or conversion-start edge powers the block up, even one landing in the same cycle as the write. Clearing the field powers up with the R6 warm-up.
- R11: The automatic field is retained across a power-down, so after waking, the next frame end powers down again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip-select, active low |
| cnvst_n | input | 1 | Asynchronous conversion-start strobe, active low |
| sw_start | input | 1 | Software conversion-start bit |
| conv_done | input | 1 | Pulse: all requested conversions finished |
| int_clk_mode | input | 1 | 1 = internal conversion clock, 0 = external |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write word |
| main_en | output | 1 | Enable for the main analog circuitry |
| bias_en | output | 1 | Enable for the bias generator |
| conv_valid | output | 1 | Conversion results may be trusted |

## Verification
The delicate overlap is a static-shutdown write and a synchronised chip-select wake edge arriving together, or nearly together, while the block is powered down. The bench lowers chip-select and then issues the configuration write 0 to 3 cycles later. With the synchroniser depth, this makes the write's effect land before, on, or after the wake edge, and at the final warm-up step. In every offset, main_en must end low and conv_valid must never rise in the window.

// File: rtl/adc_pwr_pkg.sv
`timescale 1ns/1ps
package adc_pwr_pkg;
    localparam int WORD_W   = 16;
    localparam int PM_LSB   = 2;
    localparam int SS_LSB   = 0;
    localparam logic [4:0] CFG_TAG = 5'b10000;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_ASHDN  = 2'b01,
        PM_ASTBY  = 2'b10,
        PM_SPARE  = 2'b11
    } pm_e;

    typedef enum logic [1:0] {
        SS_NONE = 2'b00,
        SS_FULL = 2'b01,
        SS_PART = 2'b10,
        SS_RSVD = 2'b11
    } ss_e;

    typedef enum logic [2:0] {
        ST_ON,
        ST_FRAME,
        ST_FRAME_NEW,
        ST_DOWN,
        ST_WARM,
        ST_WARM_F,
        ST_STATIC
    } pst_e;
endpackage

// File: rtl/adc_pwr_sync.sv
`timescale 1ns/1ps
module adc_pwr_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/adc_pwr_regs.sv
`timescale 1ns/1ps
module adc_pwr_regs
    import adc_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output pm_e               pm,
    output ss_e               ss,
    output logic              mode_wr
);
    logic mode_hit, cfg_hit;
    logic unused_bits;

    assign mode_hit    = wr_en && !wr_data[WORD_W-1];
    assign cfg_hit     = wr_en && (wr_data[WORD_W-1 -: 5] == CFG_TAG);
    assign unused_bits = ^wr_data[WORD_W-6:PM_LSB+2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pm      <= PM_NORMAL;
            ss      <= SS_NONE;
            mode_wr <= 1'b0;
        end else begin
            mode_wr <= mode_hit;
            if (mode_hit) pm <= pm_e'(wr_data[PM_LSB +: 2]);
            if (cfg_hit)  ss <= ss_e'(wr_data[SS_LSB +: 2]);
        end
    end

    AST_PM_RESET: assert property (@(posedge clk) $past(rst) |-> (pm == PM_NORMAL)); // R1
    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[WORD_W-1 -: 2] == 2'b11) |=> ($stable(pm) && $stable(ss))); // R2
endmodule

// File: rtl/adc_pwr_fsm.sv
`timescale 1ns/1ps
module adc_pwr_fsm
    import adc_pwr_pkg::*;
#(
    parameter int WARMUP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic cnv_fall,
    input  logic sw_start,
    input  logic conv_done,
    input  logic int_mode,
    input  pm_e  pm,
    input  ss_e  ss,
    input  logic mode_wr,
    output logic main_en,
    output logic bias_en,
    output logic conv_valid
);
    localparam int CNT_W = $clog2(WARMUP) + 1;

    pst_e             state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             auto_pm, ext_auto, int_auto, ss_on, warm_done;
    logic             warm_cur, warm_nxt;

    assign auto_pm   = (pm == PM_ASHDN) || (pm == PM_ASTBY);
    assign ext_auto  = auto_pm && !int_mode;
    assign int_auto  = auto_pm && int_mode;
    assign ss_on     = (ss == SS_FULL) || (ss == SS_PART);
    assign warm_done = (cnt == CNT_W'(WARMUP - 1));
    assign warm_cur  = (state == ST_WARM) || (state == ST_WARM_F);
    assign warm_nxt  = (nxt == ST_WARM) || (nxt == ST_WARM_F);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ON: begin
                if (int_auto && conv_done) nxt = ST_DOWN;
                else if (cs_fall)          nxt = ST_FRAME;
            end
            ST_FRAME: begin
                if (int_auto && conv_done) nxt = ST_DOWN;
                else if (mode_wr)          nxt = ST_FRAME_NEW;
                else if (cs_rise)          nxt = ext_auto ? ST_DOWN : ST_ON;
            end
            ST_FRAME_NEW: begin
                if (int_auto && conv_done) nxt = ST_DOWN;
                else if (cs_rise)          nxt = ST_ON;
            end
            ST_DOWN: begin
                if (!auto_pm) nxt = ST_WARM;
                else if (int_mode) begin
                    if (cnv_fall || (cs_rise && sw_start)) nxt = ST_WARM;
                end else if (cs_fall) nxt = ST_WARM_F;
            end
            ST_WARM: begin
                if (warm_done) nxt = ST_ON;
            end
            ST_WARM_F: begin
                if (cs_rise)        nxt = ext_auto ? ST_DOWN : ST_WARM;
                else if (warm_done) nxt = ST_FRAME;
            end
            ST_STATIC: begin
                if (!ss_on) nxt = ST_WARM;
            end
            default: nxt = ST_ON;
        endcase
        if (ss_on) nxt = ST_STATIC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ON;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (warm_cur && warm_nxt) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        main_en    = 1'b1;
        bias_en    = 1'b1;
        conv_valid = 1'b0;
        unique case (state)
            ST_ON, ST_FRAME, ST_FRAME_NEW: conv_valid = 1'b1;
            ST_WARM, ST_WARM_F:            conv_valid = 1'b0;
            ST_DOWN: begin
                main_en = 1'b0;
                bias_en = (pm == PM_ASTBY);
            end
            ST_STATIC: begin
                main_en = 1'b0;
                bias_en = (ss == SS_PART);
            end
            default: conv_valid = 1'b0;
        endcase
    end

    AST_BIAS_WITH_MAIN: assert property (@(posedge clk) disable iff (rst)
        main_en |-> bias_en); // R5
    AST_WARM_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(main_en) |-> !conv_valid); // R6
    AST_WARM_SECOND: assert property (@(posedge clk) disable iff (rst)
        $rose(main_en) |=> !conv_valid); // R6
    AST_STATIC_OFF: assert property (@(posedge clk) disable iff (rst)
        ss_on |=> !main_en); // R9
    AST_INT_DONE_DOWN: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && int_auto && conv_done && !ss_on) |=> !main_en); // R7
endmodule

// File: rtl/adc_pwr_seq.sv
`timescale 1ns/1ps
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WARMUP      = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        cnvst_n,
    input  logic        sw_start,
    input  logic        conv_done,
    input  logic        int_clk_mode,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic        main_en,
    output logic        bias_en,
    output logic        conv_valid
);
    logic cs_rise, cs_fall, cnv_fall, cnv_rise_unused;
    pm_e  pm;
    ss_e  ss;
    logic mode_wr;

    adc_pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .din(cs_n), .rise(cs_rise), .fall(cs_fall)
    );

    adc_pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cnv_sync (
        .clk(clk), .rst(rst), .din(cnvst_n), .rise(cnv_rise_unused), .fall(cnv_fall)
    );

    adc_pwr_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pm(pm), .ss(ss), .mode_wr(mode_wr)
    );

    adc_pwr_fsm #(.WARMUP(WARMUP)) u_fsm (
        .clk(clk), .rst(rst),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cnv_fall(cnv_fall),
        .sw_start(sw_start), .conv_done(conv_done), .int_mode(int_clk_mode),
        .pm(pm), .ss(ss), .mode_wr(mode_wr),
        .main_en(main_en), .bias_en(bias_en), .conv_valid(conv_valid)
    );
endmodule

// File: tb/sim_adc_pwr_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        cnvst_n = 1'b1;
    logic        sw_start = 1'b0;
    logic        conv_done = 1'b0;
    logic        int_clk_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        main_en, bias_en, conv_valid;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    adc_pwr_seq u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cnvst_n(cnvst_n), .sw_start(sw_start),
        .conv_done(conv_done), .int_clk_mode(int_clk_mode), .wr_en(wr_en),
        .wr_data(wr_data), .main_en(main_en), .bias_en(bias_en), .conv_valid(conv_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mode_word(input int pm);
        return 16'(pm << 2);
    endfunction

    function automatic logic [15:0] cfg_word(input int ss);
        return 16'h8000 | 16'(ss);
    endfunction

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
    endtask

    task automatic measure_wake(input string req);
        int w = 0;
        repeat (10) begin
            @(negedge clk);
            if (main_en && !conv_valid) w++;
        end
        check(req, w, 2);
        check(req, main_en, 1);
        check(req, conv_valid, 1);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        check("R1 main", main_en, 1);
        check("R1 bias", bias_en, 1);
        check("R1 valid", conv_valid, 1);

        // R2: foreign words leave everything unchanged
        wr(16'hC001); tick(4);
        check("R2 tag 11000", main_en, 1);
        wr(16'h8801); tick(4);
        check("R2 tag 10001", main_en, 1);

        // R3: non-automatic fields keep power on
        for (int pm = 0; pm < 4; pm += 3) begin
            for (int im = 0; im < 2; im++) begin
                int_clk_mode = im[0];
                wr(mode_word(pm));
                set_cs(0); tick(5); set_cs(1); tick(5);
                set_cs(0); tick(5); set_cs(1); tick(5);
                cnvst_n = 0; tick(4); cnvst_n = 1;
                conv_done = 1; tick(1); conv_done = 0; tick(4);
                check("R3 main", main_en, 1);
                check("R3 valid", conv_valid, 1);
            end
        end
        int_clk_mode = 0;

        // R4 R5 R6 R11: external-clock automatic modes
        for (int pm = 1; pm < 3; pm++) begin
            set_cs(0); tick(3);
            wr(mode_word(pm)); tick(3);
            set_cs(1); tick(5);
            check("R4 write frame", main_en, 1);
            set_cs(0); tick(5);
            check("R4 next frame", main_en, 1);
            set_cs(1); tick(5);
            check("R5 main", main_en, 0);
            check("R5 bias", bias_en, (pm == 2) ? 1 : 0);
            set_cs(0);
            measure_wake("R6 cs wake");
            set_cs(1); tick(5);
            check("R11 retained", main_en, 0);
            wr(mode_word(0)); tick(6);
            check("R11 restore", main_en, 1);
        end

        // R7 R8: internal-clock automatic modes
        int_clk_mode = 1;
        for (int pm = 1; pm < 3; pm++) begin
            wr(mode_word(pm)); tick(2);
            @(negedge clk); conv_done = 1;
            @(negedge clk); conv_done = 0;
            check("R7 main", main_en, 0);
            check("R7 bias", bias_en, (pm == 2) ? 1 : 0);
            set_cs(0); tick(5);
            check("R8 cs fall ignored", main_en, 0);
            set_cs(1); tick(5);
            check("R8 cs rise no sw", main_en, 0);
            @(negedge clk); cnvst_n = 0;
            measure_wake("R8 cnvst wake");
            cnvst_n = 1; tick(3);
            @(negedge clk); conv_done = 1;
            @(negedge clk); conv_done = 0;
            check("R7 again", main_en, 0);
            sw_start = 1;
            set_cs(0); tick(5);
            check("R8 sw cs fall", main_en, 0);
            set_cs(1);
            measure_wake("R8 sw wake");
            sw_start = 0;
            wr(mode_word(0)); tick(3);
        end
        int_clk_mode = 0;

        // R9 R10: static field sweep over every automatic field
        for (int pm = 0; pm < 4; pm++) begin
            for (int ss = 0; ss < 4; ss++) begin
                bit st;
                st = (ss == 1) || (ss == 2);
                wr(mode_word(pm));
                wr(cfg_word(ss)); tick(3);
                check("R9 main", main_en, st ? 0 : 1);
                check("R9 bias", bias_en, (ss == 1) ? 0 : 1);
                if (st) begin
                    set_cs(0); tick(5); set_cs(1); tick(5);
                    cnvst_n = 0; tick(5); cnvst_n = 1; tick(3);
                    check("R10 no wake", main_en, 0);
                    wr(cfg_word(0));
                    measure_wake("R10 release");
                end else begin
                    wr(cfg_word(0)); tick(2);
                end
                wr(mode_word(0)); tick(4);
            end
        end

        // R10: static write racing a chip-select wake
        wr(mode_word(1)); tick(2);
        for (int d = 0; d < 4; d++) begin
            int vseen = 0;
            set_cs(0); tick(5); set_cs(1); tick(5);
            check("R10 pre down", main_en, 0);
            @(negedge clk);
            cs_n = 0;
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                if (conv_valid) vseen++;
            end
            wr_en = 1; wr_data = cfg_word(1);
            @(negedge clk);
            wr_en = 0;
            repeat (8) begin
                if (conv_valid) vseen++;
                @(negedge clk);
            end
            check("R10 race main", main_en, 0);
            check("R10 race valid", vseen, 0);
            wr(cfg_word(0));
            measure_wake("R10 race release");
            set_cs(1); tick(4);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule